// File: doc/BRIEF.md
# Software Stop Reset Sequencer

This block turns a host write to a stop control bit into an orderly partial reset of a network controller. It watches the host register write port. A stop starts only when software writes a 1 to the stop bit while that bit reads 0. The block does not apply the reset at once. If the controller is asking for the bus when the write lands, the block keeps that request asserted until the grant arrives. In every case it then waits for the count of scheduled bus-master transfers to reach zero. Only after that does it pulse the partial-reset strobes for the three control/status register groups and restart the internal microcode sequencer.

The block also stands between the chip's reset inputs and the rest of the controller. It forwards both the power-on and the hardware reset as one hardware-reset output. It raises an extra clear output that only a power-on reset drives. After either reset is released it requests a single configuration-EEPROM load. A stop reset never requests that load. A reset that arrives while a stop is pending cancels the stop. The orderly way to quiet traffic first is the suspend bit, which sits in a separate register. The block stores that bit, and a stop reset leaves it as it is.

Top module: `stop_reset_seq`

## Requirements
- R1: While porIn or hwRstIn is high, and after either is released, stopBitOut reads 1, while stopPending, seqRestart, grpRst and suspendOut read 0.
- R2: A write to address 0 with data bit 2 = 1 while stopBitOut reads 0 and no stop is pending raises stopPending on the next cycle.
- R3: A write of 1 to bit 2 of address 0 while stopBitOut already reads 1 does not start a stop: stopPending stays 0 and no strobe follows. A write of 0 to that bit starts nothing either.
- R4: If busReqIn is high in the cycle the qualifying write is taken, busReqOut stays high from then until busGnt is seen, even if busReqIn drops. No strobe is issued before that grant.
- R5: No strobe is issued while pendCnt is nonzero. The strobe appears the cycle after pendCnt is observed as zero, once any grant that is needed has been seen.
- R6: A stop reset drives all bits of grpRst and seqRestart high together for exactly one cycle. stopPending is low in that cycle and in the cycles after it.
- R7: Each write to address 0 loads bit 2 into the stop bit. After a stop reset the bit keeps reading 1 until a write with bit 2 = 0 clears it, for example a start command (bit 1 = 1, bit 2 = 0).
- R8: eepromLoad pulses for exactly one cycle after porIn or hwRstIn is released. It never pulses because of a stop reset.
- R9: hwRstOut is high on the cycle after either reset input is high. porClrOut is high on the cycle after porIn is high and stays low for a plain hardware reset.
- R10: A power-on or hardware reset during a pending stop cancels it: stopPending drops and no strobe is issued afterwards.
- R11: A write to address 5 loads its bit 0 into suspendOut. A stop reset leaves suspendOut unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porIn | input | 1 | Power-on reset, active high |
| hwRstIn | input | 1 | Hardware reset, active high |
| regWrEn | input | 1 | Host register write strobe |
| regWrAddr | input | 4 | Host register write address |
| regWrData | input | 16 | Host register write data |
| busReqIn | input | 1 | Bus request from the master engine |
| busGnt | input | 1 | Bus grant |
| pendCnt | input | 4 | Number of bus-master transfers still scheduled |
| busReqOut | output | 1 | Bus request toward the arbiter |
| grpRst | output | 3 | Partial-reset strobes for control/status register groups 0, 3 and 4 |
| seqRestart | output | 1 | Microcode sequencer restart strobe |
| stopPending | output | 1 | Stop accepted but not yet applied |
| stopBitOut | output | 1 | Current value of the stop bit |
| suspendOut | output | 1 | Current value of the suspend bit |
| hwRstOut | output | 1 | Hardware reset toward the controller |
| porClrOut | output | 1 | Extra clear driven only by power-on reset |
| eepromLoad | output | 1 | Request to load configuration from EEPROM |

## Verification
The bench replays writes of 1 to a stop bit that already reads 1. A design that detects the level of the written bit instead of the 0-to-1 change would fire a second strobe there. The bench also drops the master's request right after the stop write while holding the grant back. A design that let the request fall, or fired before the grant, shows up as a low busReqOut or an early strobe. It counts pendCnt down and looks for the strobe on the exact cycle after the count reaches zero, which catches designs that fire while transfers remain or that are off by one cycle. Finally it resets the block in the middle of a pending stop and watches that no strobe leaks out afterwards. It also counts EEPROM load pulses across stops to catch a design that reloads the configuration after a stop.

// File: rtl/stop_seq_pkg.sv
package stop_seq_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_GNT   = 2'd1,
    S_DRAIN = 2'd2,
    S_FIRE  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic fire;     // apply the partial reset this cycle
    logic holdReq;  // keep the bus request up until grant
    logic pending;  // stop accepted, not yet applied
  } ctlStrb_t;

endpackage

// File: rtl/stop_seq_ctl.sv
module stop_seq_ctl
  import stop_seq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstAny,
  input  logic             qualify,
  input  logic             busReqIn,
  input  logic             busGnt,
  input  logic [CNT_W-1:0] pendCnt,
  output ctlStrb_t         strb
);

  seqState_t state;
  seqState_t stateNxt;
  logic      drained;

  assign drained = (pendCnt == '0);

  always_comb begin
    stateNxt = state;
    case (state)
      S_IDLE: begin
        if (qualify) begin
          stateNxt = busReqIn ? S_GNT : S_DRAIN;
        end
      end
      S_GNT: begin
        if (busGnt) begin
          stateNxt = S_DRAIN;
        end
      end
      S_DRAIN: begin
        if (drained) begin
          stateNxt = S_FIRE;
        end
      end
      S_FIRE: begin
        stateNxt = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rstAny) begin
      state <= S_IDLE;
    end else begin
      state <= stateNxt;
    end
  end

  assign strb.fire    = (state == S_FIRE);
  assign strb.holdReq = (state == S_GNT);
  assign strb.pending = (state == S_GNT) || (state == S_DRAIN);

  // R5: never fire while scheduled transfers remain
  assert_no_fire_busy_R5: assert property (@(posedge clk) disable iff (rstAny)
    (pendCnt != '0) |=> !strb.fire);

  // R4: while waiting for the grant, the next cycle never fires
  assert_no_fire_before_grant_R4: assert property (@(posedge clk) disable iff (rstAny)
    strb.holdReq |=> !strb.fire);

  // R6: the strobe is a single cycle
  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (rstAny)
    strb.fire |=> !strb.fire);

endmodule

// File: rtl/stop_seq_dp.sv
module stop_seq_dp
  import stop_seq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int NUM_GRP   = 3,
  parameter int CTL_ADDR  = 0,
  parameter int SUSP_ADDR = 5,
  parameter int STOP_BIT  = 2,
  parameter int SUSP_BIT  = 0
) (
  input  logic              clk,
  input  logic              porIn,
  input  logic              hwRstIn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              busReqIn,
  input  ctlStrb_t          strb,
  output logic              rstAny,
  output logic              qualify,
  output logic              busReqOut,
  output logic [NUM_GRP-1:0] grpRst,
  output logic              seqRestart,
  output logic              stopPending,
  output logic              stopBitOut,
  output logic              suspendOut,
  output logic              hwRstOut,
  output logic              porClrOut,
  output logic              eepromLoad
);

  localparam logic [ADDR_W-1:0] CTL_A  = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] SUSP_A = ADDR_W'(SUSP_ADDR);

  logic stopBitQ;
  logic suspQ;
  logic rstQ;
  logic hwRstQ;
  logic porClrQ;
  logic eeLoadQ;
  logic ctlWr;
  logic suspWr;

  assign rstAny = porIn | hwRstIn;
  assign ctlWr  = regWrEn && (regWrAddr == CTL_A);
  assign suspWr = regWrEn && (regWrAddr == SUSP_A);

  // a stop starts only on a 0-to-1 change of the stop bit
  assign qualify = ctlWr && regWrData[STOP_BIT] && !stopBitQ && !strb.pending;

  always_ff @(posedge clk) begin
    if (rstAny) begin
      stopBitQ <= 1'b1;
      suspQ    <= 1'b0;
    end else begin
      if (ctlWr) begin
        stopBitQ <= regWrData[STOP_BIT];
      end
      if (suspWr) begin
        suspQ <= regWrData[SUSP_BIT];
      end
    end
  end

  // reset forwarding and the post-reset EEPROM load
  always_ff @(posedge clk) begin
    rstQ    <= rstAny;
    hwRstQ  <= rstAny;
    porClrQ <= porIn;
    eeLoadQ <= rstQ & ~rstAny;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : gen_grp
      assign grpRst[g] = strb.fire;
    end
  endgenerate

  assign seqRestart  = strb.fire;
  assign busReqOut   = busReqIn | strb.holdReq;
  assign stopPending = strb.pending;
  assign stopBitOut  = stopBitQ;
  assign suspendOut  = suspQ;
  assign hwRstOut    = hwRstQ;
  assign porClrOut   = porClrQ;
  assign eepromLoad  = eeLoadQ;

  // R2: a qualifying write makes the stop pending on the next cycle
  assert_qualify_R2: assert property (@(posedge clk) disable iff (rstAny)
    qualify |=> stopPending);

  // R3: writing 1 over a 1 with nothing pending starts nothing
  assert_ignore_set_R3: assert property (@(posedge clk) disable iff (rstAny)
    (ctlWr && regWrData[STOP_BIT] && stopBitQ && !stopPending) |=> !stopPending);

  // R8: a stop reset never coincides with an EEPROM load
  assert_no_ee_on_stop_R8: assert property (@(posedge clk) disable iff (rstAny)
    seqRestart |-> !eepromLoad);

  // R10: a reset clears any pending stop by the next cycle
  assert_cancel_R10: assert property (@(posedge clk)
    rstAny |=> (!stopPending && !seqRestart));

  // R11: a stop reset leaves the suspend bit alone
  assert_susp_kept_R11: assert property (@(posedge clk) disable iff (rstAny)
    (seqRestart && !suspWr) |=> $stable(suspendOut));

endmodule

// File: rtl/stop_reset_seq.sv
module stop_reset_seq
  import stop_seq_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 4,
  parameter int NUM_GRP = 3
) (
  input  logic               clk,
  input  logic               porIn,
  input  logic               hwRstIn,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regWrAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               busReqIn,
  input  logic               busGnt,
  input  logic [CNT_W-1:0]   pendCnt,
  output logic               busReqOut,
  output logic [NUM_GRP-1:0] grpRst,
  output logic               seqRestart,
  output logic               stopPending,
  output logic               stopBitOut,
  output logic               suspendOut,
  output logic               hwRstOut,
  output logic               porClrOut,
  output logic               eepromLoad
);

  ctlStrb_t strb;
  logic     rstAny;
  logic     qualify;

  stop_seq_ctl #(
    .CNT_W (CNT_W)
  ) ctl_i (
    .clk      (clk),
    .rstAny   (rstAny),
    .qualify  (qualify),
    .busReqIn (busReqIn),
    .busGnt   (busGnt),
    .pendCnt  (pendCnt),
    .strb     (strb)
  );

  stop_seq_dp #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_GRP (NUM_GRP)
  ) dp_i (
    .clk         (clk),
    .porIn       (porIn),
    .hwRstIn     (hwRstIn),
    .regWrEn     (regWrEn),
    .regWrAddr   (regWrAddr),
    .regWrData   (regWrData),
    .busReqIn    (busReqIn),
    .strb        (strb),
    .rstAny      (rstAny),
    .qualify     (qualify),
    .busReqOut   (busReqOut),
    .grpRst      (grpRst),
    .seqRestart  (seqRestart),
    .stopPending (stopPending),
    .stopBitOut  (stopBitOut),
    .suspendOut  (suspendOut),
    .hwRstOut    (hwRstOut),
    .porClrOut   (porClrOut),
    .eepromLoad  (eepromLoad)
  );

  // R4: the request held by the controller shows up at the port
  assert_req_held_R4: assert property (@(posedge clk) disable iff (rstAny)
    strb.holdReq |-> busReqOut);

endmodule

// File: tb/stop_reset_seq_tb_top.sv
`timescale 1ns/1ps
module stop_reset_seq_tb_top;

  localparam real CLK_HALF = 4.0;

  logic        clk = 1'b0;
  logic        porIn = 1'b1;
  logic        hwRstIn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regWrAddr = '0;
  logic [15:0] regWrData = '0;
  logic        busReqIn = 1'b0;
  logic        busGnt = 1'b0;
  logic [3:0]  pendCnt = '0;
  logic        busReqOut;
  logic [2:0]  grpRst;
  logic        seqRestart;
  logic        stopPending;
  logic        stopBitOut;
  logic        suspendOut;
  logic        hwRstOut;
  logic        porClrOut;
  logic        eepromLoad;

  int checks = 0;
  int failures = 0;
  int strbCnt = 0;
  int eeCnt = 0;

  always #(CLK_HALF) clk = ~clk;

  stop_reset_seq dut_i (
    .clk(clk), .porIn(porIn), .hwRstIn(hwRstIn), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData), .busReqIn(busReqIn),
    .busGnt(busGnt), .pendCnt(pendCnt), .busReqOut(busReqOut), .grpRst(grpRst),
    .seqRestart(seqRestart), .stopPending(stopPending), .stopBitOut(stopBitOut),
    .suspendOut(suspendOut), .hwRstOut(hwRstOut), .porClrOut(porClrOut),
    .eepromLoad(eepromLoad)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: counts strobes and EEPROM loads; R6 strobe shape
  always @(negedge clk) begin
    if (!porIn && !hwRstIn) begin
      if (seqRestart) strbCnt++;
      if (eepromLoad) eeCnt++;
      if (seqRestart) begin
        check("R6 grpRst all set", int'(grpRst), 7);
        check("R6 pending low at strobe", int'(stopPending), 0);
      end else begin
        check("R6 grpRst idle", int'(grpRst), 0);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [15:0] d);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  // vector: [7] bit before, [6] written value, [5] request at write,
  //         [4] strobe expected, [3:0] pending transfers
  localparam logic [7:0] VEC [8] = '{
    8'b0_1_0_1_0000, 8'b0_1_1_1_0000, 8'b0_1_0_1_0011, 8'b0_1_1_1_0010,
    8'b1_1_0_0_0000, 8'b1_1_1_0_0010, 8'b0_0_0_0_0000, 8'b1_0_1_0_0001
  };

  initial begin : watchdog
    #(CLK_HALF * 2.0 * 20000.0);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int eeBase;
    tick(3);
    // R1 and R9 during power-on reset
    check("R1 stop bit in reset", int'(stopBitOut), 1);
    check("R1 pending in reset", int'(stopPending), 0);
    check("R1 suspend in reset", int'(suspendOut), 0);
    check("R9 hwRstOut on POR", int'(hwRstOut), 1);
    check("R9 porClrOut on POR", int'(porClrOut), 1);
    porIn = 1'b0;
    tick(4);
    check("R8 one load after POR", eeCnt, 1);
    check("R9 hwRstOut released", int'(hwRstOut), 0);
    check("R1 stop bit after reset", int'(stopBitOut), 1);

    eeBase = eeCnt;
    for (int v = 0; v < 8; v++) begin
      logic pre, wv, req, fire;
      int cnt;
      {pre, wv, req, fire} = VEC[v][7:4];
      cnt = int'(VEC[v][3:0]);
      regWrite(4'd0, 16'h0000);
      if (pre) begin
        regWrite(4'd0, 16'h0004);
        tick(4);
      end
      strbCnt = 0;
      busReqIn = req; pendCnt = 4'(cnt);
      regWrite(4'd0, {13'd0, wv, 2'b00});
      check($sformatf("R2/R3 pending v%0d", v), int'(stopPending), int'(fire));
      busReqIn = 1'b0;
      if (req) begin
        tick(3);
        check($sformatf("R4 request held v%0d", v), int'(busReqOut), int'(fire));
        check($sformatf("R4 no strobe before grant v%0d", v), strbCnt, 0);
        busGnt = 1'b1;
        tick(1);
        busGnt = 1'b0;
      end
      while (pendCnt != 0) begin
        tick(1);
        check($sformatf("R5 no strobe while busy v%0d", v), strbCnt, 0);
        pendCnt = pendCnt - 1;
      end
      tick(1);
      check($sformatf("R5 strobe timing v%0d", v), int'(seqRestart), int'(fire));
      tick(3);
      check($sformatf("R6 strobe count v%0d", v), strbCnt, int'(fire));
      check($sformatf("R6 pending cleared v%0d", v), int'(stopPending), 0);
      check($sformatf("R7 stop bit v%0d", v), int'(stopBitOut), int'(wv));
    end
    check("R8 no load from stop", eeCnt, eeBase);

    // R7: start command clears the stop bit
    regWrite(4'd0, 16'h0002);
    check("R7 start clears stop", int'(stopBitOut), 0);

    // R11: suspend bit survives a stop
    regWrite(4'd5, 16'h0001);
    check("R11 suspend set", int'(suspendOut), 1);
    strbCnt = 0;
    regWrite(4'd0, 16'h0004);
    tick(4);
    check("R11 stop happened", strbCnt, 1);
    check("R11 suspend kept", int'(suspendOut), 1);

    // R10: hardware reset cancels a pending stop; R9 plain reset
    regWrite(4'd0, 16'h0000);
    strbCnt = 0;
    pendCnt = 4'd2;
    regWrite(4'd0, 16'h0004);
    check("R10 pending before reset", int'(stopPending), 1);
    hwRstIn = 1'b1;
    tick(2);
    check("R9 hwRstOut on hw reset", int'(hwRstOut), 1);
    check("R9 no porClr on hw reset", int'(porClrOut), 0);
    check("R1 suspend cleared", int'(suspendOut), 0);
    eeBase = eeCnt;
    pendCnt = 4'd0;
    hwRstIn = 1'b0;
    tick(6);
    check("R10 pending cancelled", int'(stopPending), 0);
    check("R10 no strobe after cancel", strbCnt, 0);
    check("R8 one load after hw reset", eeCnt - eeBase, 1);
    check("R1 stop bit after hw reset", int'(stopBitOut), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule